// File: doc/BRIEF.md
# Exception Gating and Trace Unit

This block sits next to the completion stage of a processor pipeline and owns the machine control word. That word decides whether floating-point work may issue, whether machine-check requests are honoured, whether single-step or branch tracing is active, and where exception vectors land in the physical address space. On each cycle the block looks at the completion event and any machine-check request. It picks at most one exception, reports a cause code and the full 32-bit vector address, and updates the control word on the next clock edge.

The completion stage gives, per cycle, a valid flag together with branch, return-from-interrupt, floating-point-class and "already faulted" markers, plus a 20-bit vector offset for the case where the instruction faulted on its own. The control word has a plain write port and a read-back port. The fields for address translation, the two floating-point exception modes and the process mark are only stored. The decode logic also receives a dispatch-block output that stops floating-point issue.

Top module: `exc_gate_unit`

## Requirements
- R1: Control bit 0 (FP enable) at 0 drives fp_block high. A valid completion of a floating-point-class instruction then raises cause 3 (FP unavailable) with offset 0x00800.
- R2: With bit 0 at 1, fp_block is low and a floating-point completion raises nothing by itself. Any completion flagged as faulted raises cause 2 with the offset supplied on the completion port.
- R3: A machine-check request raises cause 1 with offset 0x00200 only when control bit 1 (MC enable) is 1. With the bit at 0 the request has no effect.
- R4: With control bit 3 (step) at 1, a valid, non-faulted completion raises cause 4 with offset 0x00D00. A completion marked return-from-interrupt is exempt.
- R5: With control bit 4 (branch trace) at 1, a valid, non-faulted branch completion raises cause 5 with offset 0x00D00. With the bit at 0, branches raise nothing.
- R6: A completion flagged as faulted never yields cause 4 or 5 in the same cycle.
- R7: When several causes are active together, exactly one is reported. The fixed order is 1, then 2, then 3, then 4, then 5. Cause 0 means nothing was taken, and exc_take is high exactly when the cause is nonzero.
- R8: Control bit 6 (high base) selects the vector. At 0 the vector is {12'h000, offset}; at 1 it is {12'hFFF, offset}.
- R9: On the cycle after any exception is taken, bits 0, 3, 4, 7 and 8 of the control word read 0. Bits 1, 2, 5, 6 and 9 keep their values.
- R10: A write with no exception in the same cycle stores bits 9:0 of wr_data. On read-back, bits 31:10 are always 0, and bits 2, 5, 7, 8 and 9 return exactly what was written.
- R11: If a write and a taken exception fall in the same cycle, the exception update wins and the written data is discarded.
- R12: After reset the control word is 0, fp_block is high, and no exception is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | An instruction completes this cycle |
| cmp_branch | input | 1 | Completing instruction is a branch |
| cmp_rfi | input | 1 | Completing instruction is a return-from-interrupt |
| cmp_fp | input | 1 | Completing instruction is floating-point class |
| cmp_exc | input | 1 | Completing instruction raised its own exception |
| cmp_off | input | 20 | Vector offset for the instruction's own exception |
| mchk_req | input | 1 | Machine-check request |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| ctl_rd | output | 32 | Control word read-back |
| exc_take | output | 1 | An exception is taken this cycle |
| exc_cause | output | 3 | Cause code of the taken exception (0 = none) |
| exc_vec | output | 32 | Physical vector address (0 when none) |
| fp_block | output | 1 | Block dispatch of floating-point-class instructions |

## Verification
Two events can land in the same cycle: a write to the control word and a taken exception. Both update the same register. The bench arms the step bit and then, in one cycle, presents a completion together with a write of all-zero or all-one data. On the following cycle it reads the word back and expects the trace-driven clearing pattern, not the written data. Within a single cycle, all pairings of machine check, own fault, FP-unavailable, step and branch trace are swept together. Each pairing is judged against an independently computed priority winner and vector.

// File: rtl/exc_gate_pkg.sv
package exc_gate_pkg;
  localparam int CAUSE_W = 3;
  localparam int NUM_SRC = 5;

  // control word bit positions
  localparam int B_FPEN = 0;
  localparam int B_MCEN = 1;
  localparam int B_FM0  = 2;
  localparam int B_STEP = 3;
  localparam int B_BRTR = 4;
  localparam int B_FM1  = 5;
  localparam int B_HIGH = 6;
  localparam int B_ITR  = 7;
  localparam int B_DTR  = 8;
  localparam int B_MARK = 9;
  localparam int CTL_USED = 10;

  // cause codes; numeric order equals priority order
  typedef enum logic [CAUSE_W-1:0] {
    CZ_NONE = 3'd0,
    CZ_MCHK = 3'd1,
    CZ_PROG = 3'd2,
    CZ_FPU  = 3'd3,
    CZ_STEP = 3'd4,
    CZ_BRT  = 3'd5
  } cause_e;
endpackage

// File: rtl/exc_ctl_reg.sv
module exc_ctl_reg #(
  parameter int          W         = 32,
  parameter logic [W-1:0] RD_MASK  = 32'h0000_03FF,
  parameter logic [W-1:0] KEEP_MASK = 32'h0000_0266
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (take)       nxt = q & KEEP_MASK;
    else if (wr_en) nxt = wr_data & RD_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R9
  clear_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((q & ~KEEP_MASK) == '0) && ((q & KEEP_MASK) == ($past(q) & KEEP_MASK)));

  // R11
  take_over_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_en) |=> ((q & ~KEEP_MASK) == '0));

  // R10
  write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !take) |=> (q == ($past(wr_data) & RD_MASK)));
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
  parameter int N     = 5,
  parameter int CODE_W = $clog2(N + 1)
) (
  input  logic [N-1:0]      req,
  output logic [N-1:0]      gnt,
  output logic [CODE_W-1:0] code
);
  // req[0] is the highest priority
  for (genvar k = 0; k < N; k++) begin : g_gnt
    if (k == 0) begin : g_top
      assign gnt[k] = req[k];
    end else begin : g_rest
      assign gnt[k] = req[k] & ~(|req[k-1:0]);
    end
  end

  always_comb begin
    code = '0;
    for (int k = 0; k < N; k++)
      if (gnt[k]) code = CODE_W'(k + 1);
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 20
) (
  input  logic              hi_base,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] vec
);
  localparam int BASE_W = ADDR_W - OFF_W;

  function automatic logic [ADDR_W-1:0] place(input logic hi, input logic [OFF_W-1:0] o);
    return {{BASE_W{hi}}, o};
  endfunction

  assign vec = place(hi_base, off);
endmodule

// File: rtl/exc_gate_unit.sv
module exc_gate_unit
  import exc_gate_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter int               OFF_W    = 20,
  parameter int               CTL_W    = 32,
  parameter logic [OFF_W-1:0] MCHK_OFF = 20'h00200,
  parameter logic [OFF_W-1:0] FPU_OFF  = 20'h00800,
  parameter logic [OFF_W-1:0] TRC_OFF  = 20'h00D00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_valid,
  input  logic               cmp_branch,
  input  logic               cmp_rfi,
  input  logic               cmp_fp,
  input  logic               cmp_exc,
  input  logic [OFF_W-1:0]   cmp_off,
  input  logic               mchk_req,
  input  logic               wr_en,
  input  logic [CTL_W-1:0]   wr_data,
  output logic [CTL_W-1:0]   ctl_rd,
  output logic               exc_take,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [ADDR_W-1:0]  exc_vec,
  output logic               fp_block
);
  localparam logic [CTL_W-1:0] RD_MASK   = CTL_W'((1 << CTL_USED) - 1);
  localparam logic [CTL_W-1:0] CLR_MASK  = CTL_W'((1 << B_FPEN) | (1 << B_STEP) | (1 << B_BRTR)
                                                  | (1 << B_ITR) | (1 << B_DTR));
  localparam logic [CTL_W-1:0] KEEP_MASK = RD_MASK & ~CLR_MASK;

  logic [CTL_W-1:0]   ctl_q;
  logic               fp_en, mc_en, step_en, brtr_en, hi_base;
  logic               ev_mchk, ev_prog, ev_fpu, ev_step, ev_brt;
  logic [NUM_SRC-1:0] req, gnt;
  logic [CAUSE_W-1:0] code;
  logic [OFF_W-1:0]   sel_off;
  logic [ADDR_W-1:0]  raw_vec;

  exc_ctl_reg #(.W(CTL_W), .RD_MASK(RD_MASK), .KEEP_MASK(KEEP_MASK)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(exc_take), .q(ctl_q)
  );

  assign fp_en   = ctl_q[B_FPEN];
  assign mc_en   = ctl_q[B_MCEN];
  assign step_en = ctl_q[B_STEP];
  assign brtr_en = ctl_q[B_BRTR];
  assign hi_base = ctl_q[B_HIGH];

  // candidate events, each named for the checks
  assign ev_mchk = mchk_req & mc_en;
  assign ev_prog = cmp_valid & cmp_exc;
  assign ev_fpu  = cmp_valid & cmp_fp & ~fp_en;
  assign ev_step = cmp_valid & step_en & ~cmp_rfi & ~cmp_exc;
  assign ev_brt  = cmp_valid & brtr_en & cmp_branch & ~cmp_exc;

  assign req = {ev_brt, ev_step, ev_fpu, ev_prog, ev_mchk};

  exc_prio_arb #(.N(NUM_SRC), .CODE_W(CAUSE_W)) u_arb (
    .req(req), .gnt(gnt), .code(code)
  );

  always_comb begin
    unique case (cause_e'(code))
      CZ_MCHK:         sel_off = MCHK_OFF;
      CZ_PROG:         sel_off = cmp_off;
      CZ_FPU:          sel_off = FPU_OFF;
      CZ_STEP, CZ_BRT: sel_off = TRC_OFF;
      default:         sel_off = '0;
    endcase
  end

  exc_vector #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_vec (
    .hi_base(hi_base), .off(sel_off), .vec(raw_vec)
  );

  assign exc_take  = |gnt;
  assign exc_cause = code;
  assign exc_vec   = exc_take ? raw_vec : '0;
  assign ctl_rd    = ctl_q;
  assign fp_block  = ~fp_en;

  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && (exc_take == (exc_cause != CZ_NONE)));

  // R3
  mchk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mchk_req && ctl_rd[B_MCEN]) |-> (exc_take && exc_cause == CZ_MCHK));

  // R3
  mchk_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rd[B_MCEN] |-> (exc_cause != CZ_MCHK));

  // R6
  no_trace_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_exc) |-> (exc_cause != CZ_STEP && exc_cause != CZ_BRT));

  // R4
  rfi_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_rfi |-> (exc_cause != CZ_STEP));

  // R8
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> (exc_vec[ADDR_W-1:OFF_W] == {(ADDR_W-OFF_W){ctl_rd[B_HIGH]}}));

  // R1
  fp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_fp && fp_block && !cmp_exc) |-> exc_take);
endmodule

// File: tb/sim_exc_gate_unit.sv
`timescale 1ns/1ps
module sim_exc_gate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0, cmp_branch = 1'b0, cmp_rfi = 1'b0, cmp_fp = 1'b0, cmp_exc = 1'b0;
  logic [19:0] cmp_off = '0;
  logic        mchk_req = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctl_rd;
  logic        exc_take;
  logic [2:0]  exc_cause;
  logic [31:0] exc_vec;
  logic        fp_block;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  exc_gate_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_branch(cmp_branch),
    .cmp_rfi(cmp_rfi), .cmp_fp(cmp_fp), .cmp_exc(cmp_exc), .cmp_off(cmp_off),
    .mchk_req(mchk_req), .wr_en(wr_en), .wr_data(wr_data), .ctl_rd(ctl_rd),
    .exc_take(exc_take), .exc_cause(exc_cause), .exc_vec(exc_vec), .fp_block(fp_block)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // control word from a 5-bit pattern: fpen, mcen, step, brtr, high + stored-only bits
  function automatic logic [31:0] ctl_of(input logic [4:0] c);
    logic [31:0] v;
    v = 32'(c[0]) | (32'(c[1]) << 1) | (32'(c[2]) << 3) | (32'(c[3]) << 4) | (32'(c[4]) << 6);
    if (c[0]) v = v | 32'h180;
    if (c[1]) v = v | 32'h224;
    return v;
  endfunction

  task automatic write_ctl(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v; cmp_valid = 1'b0; mchk_req = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ecause;
    logic [19:0] eoff;
    logic [31:0] cv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12
    check("R12 ctl", ctl_rd, 32'h0);
    check("R12 take", {31'b0, exc_take}, 32'h0);
    check("R12 cause", {29'b0, exc_cause}, 32'h0);
    check("R12 fp_block", {31'b0, fp_block}, 32'h1);

    for (int c = 0; c < 32; c++) begin
      for (int i = 0; i < 32; i++) begin
        cv = ctl_of(5'(c));
        write_ctl(cv | 32'hFFFF_FC00);
        // R10: reserved bits read zero, stored-only bits unchanged
        check("R10 readback", ctl_rd, cv);
        cmp_valid = 1'b1;
        cmp_branch = i[0]; cmp_rfi = i[1]; cmp_fp = i[2]; cmp_exc = i[3]; mchk_req = i[4];
        cmp_off = {5'(i), 5'(c), 10'h2A5};
        #1;
        // expected per R1..R7
        if (i[4] && c[1])                  begin ecause = 1; eoff = 20'h00200; end
        else if (i[3])                     begin ecause = 2; eoff = cmp_off;   end
        else if (i[2] && !c[0])            begin ecause = 3; eoff = 20'h00800; end
        else if (c[2] && !i[1])            begin ecause = 4; eoff = 20'h00D00; end
        else if (c[3] && i[0])             begin ecause = 5; eoff = 20'h00D00; end
        else                               begin ecause = 0; eoff = 20'h0;     end
        check("R7 take", {31'b0, exc_take}, {31'b0, ecause != 0});
        check("R7 cause R3 R4 R5 R6", {29'b0, exc_cause}, 32'(ecause));
        check("R1 fp_block", {31'b0, fp_block}, {31'b0, !c[0]});
        if (ecause != 0)
          check("R8 vector", exc_vec, {{12{c[4]}}, eoff});
        @(negedge clk);
        cmp_valid = 1'b0; mchk_req = 1'b0;
        #1;
        // R9
        check("R9 post", ctl_rd, (ecause != 0) ? (cv & 32'h266) : cv);
      end
    end

    // R2: fp enabled, plain fp completion raises nothing
    write_ctl(32'h1);
    cmp_valid = 1'b1; cmp_fp = 1'b1; cmp_exc = 1'b0; cmp_branch = 1'b0; cmp_rfi = 1'b0;
    #1;
    check("R2 fp ok", {31'b0, exc_take}, 32'h0);
    @(negedge clk);
    cmp_valid = 1'b0;

    // R11: write together with a step trace, all-ones data
    write_ctl(32'h3FF);
    cmp_valid = 1'b1; cmp_fp = 1'b0; cmp_exc = 1'b0;
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    #1;
    check("R11 take", {29'b0, exc_cause}, 32'd4);
    @(negedge clk);
    cmp_valid = 1'b0; wr_en = 1'b0;
    #1;
    check("R11 ones", ctl_rd, 32'h266);

    // R11: write of zero together with a step trace keeps the kept bits
    write_ctl(32'h3FF);
    cmp_valid = 1'b1; wr_en = 1'b1; wr_data = 32'h0;
    @(negedge clk);
    cmp_valid = 1'b0; wr_en = 1'b0;
    #1;
    check("R11 zero", ctl_rd, 32'h266);

    // R3: no completion, masked machine check ignored; no-completion gives nothing
    write_ctl(32'h3FD);
    mchk_req = 1'b1; cmp_branch = 1'b1;
    #1;
    check("R3 masked", {31'b0, exc_take}, 32'h0);
    @(negedge clk);
    mchk_req = 1'b0; cmp_branch = 1'b0;
    #1;
    check("R3 state kept", ctl_rd, 32'h3FD);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule